// File: doc/BRIEF.md
# Time-Interleaved SAR Conversion Sequencer

This block sequences sixteen successive-approximation converter slices that share one input clock. A free-running phase counter walks every slice through the same sixteen-step frame: a reference-zero step, an offset-null compare, a gain-trim compare, the input-sample step, eleven binary-search steps, and a transfer step. Each slice runs one clock behind its lower neighbour, so exactly one slice takes the input on every clock. Each slice's comparator decision comes in on an input pin. Each slice puts out its current trial code so that an analog front end, or a behavioural model, can answer the comparison.

A rotating selector picks the slice that is in its transfer step. It loads that result into a registered 10-bit word with an overrange flag and a data-valid strobe. The chip level holds two such channels. Each has its own clock and reset, and one active-low enable switches both data buses to high impedance.

Top module: `tis_dual_top`

## Requirements
- R1: While reset is asserted and during the first 16 cycles after release, the data-valid strobe is 0 and the data word and overrange flag read 0.
- R2: In cycle n after reset release, slice k is at step (n - k) mod 16. Its trial code is nonzero only in steps 4 to 14, so exactly 11 slices are searching on every cycle, and exactly one of them is in its first search step (trial code 1024).
- R3: The search resolves the 11-bit code MSB first. Each step offers trial = kept bits OR the current bit, and keeps that bit when the comparator input is 1. A comparator that answers "sample >= trial" therefore yields a result equal to the sampled code.
- R4: A slice ignores its comparator input in steps 0 to 3 and 15. Toggling the input in those steps does not change any output word.
- R5: The code sampled by the slice at step 3 in cycle c appears on the data outputs throughout cycle c + 13, twelve rising edges after the sampling edge.
- R6: If the 11-bit result is 1024 or more, the overrange flag is 1 and the data word is 1023. Otherwise the flag is 0 and the data word equals the result.
- R7: The data-valid strobe rises at the start of cycle 16 after reset release and stays high while the clock runs.
- R8: While the active-low enable is 1, both data words and both overrange flags are high impedance. The data-valid strobes are unaffected.
- R9: The two channels run from their own clocks and resets. Holding one channel in reset does not disturb the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Channel A clock |
| rst_a_ni | input | 1 | Channel A asynchronous reset, active low |
| cmp_a_i | input | 16 | Channel A comparator decisions, one per slice |
| trial_a_o | output | 176 | Channel A trial codes, slice k at bits [11k+10:11k] |
| clk_b_i | input | 1 | Channel B clock |
| rst_b_ni | input | 1 | Channel B asynchronous reset, active low |
| cmp_b_i | input | 16 | Channel B comparator decisions |
| trial_b_o | output | 176 | Channel B trial codes |
| oe_ni | input | 1 | Shared output enable, active low |
| data_a_o | output | 10 | Channel A result word, tri-state |
| ovr_a_o | output | 1 | Channel A overrange flag, tri-state |
| dav_a_o | output | 1 | Channel A data-valid strobe |
| data_b_o | output | 10 | Channel B result word, tri-state |
| ovr_b_o | output | 1 | Channel B overrange flag, tri-state |
| dav_b_o | output | 1 | Channel B data-valid strobe |

## Verification
The assertions assume that the enable stays low whenever the overrange-to-saturation property is read, and they gate that property with the enable. They also assume that each clock runs without pause after its reset is released, because the valid-strobe window is counted in clock edges. The bench answers each comparator only from the slice's own trial code and the code it sampled for that slice. In the steps where the answer must be ignored, it drives a toggling value instead. Each channel sweeps every one of the 2048 sample codes, with different orderings and clock periods, and the bench releases channel B well after channel A.

// File: rtl/tis_pkg.sv
package tis_pkg;
  localparam int DATA_W    = 10;
  localparam int SAR_W     = DATA_W + 1;
  localparam int SLICES    = 16;
  localparam int PH_W      = $clog2(SLICES);
  localparam int STEP_REF  = 0;
  localparam int STEP_SMP  = 3;
  localparam int STEP_SAR0 = 4;
  localparam int STEP_XFER = SLICES - 1;

  typedef logic [PH_W-1:0]  phase_t;
  typedef logic [SAR_W-1:0] code_t;
endpackage

// File: rtl/tis_phase_gen.sv
module tis_phase_gen
  import tis_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_t phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= '0;
    else         phase_o <= phase_o + phase_t'(1);
  end
endmodule

// File: rtl/tis_sar_slice.sv
module tis_sar_slice
  import tis_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_t phase_i,
  input  logic   cmp_i,
  output code_t  trial_o,
  output code_t  code_o,
  output logic   ready_o
);
  phase_t step, bit_idx;
  code_t  res_q, mask;
  logic   armed_q, in_sar;

  assign step    = phase_i - phase_t'(IDX);
  assign in_sar  = (step >= phase_t'(STEP_SAR0)) && (step < phase_t'(STEP_XFER));
  // step 4 tries bit SAR_W-1, step 14 tries bit 0
  assign bit_idx = phase_t'(STEP_XFER - 1) - step;
  assign mask    = code_t'(1) << bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      armed_q <= 1'b0;
    end else if (step == phase_t'(STEP_REF)) begin
      res_q   <= '0;
      armed_q <= 1'b1;
    end else if (step == phase_t'(STEP_SMP)) begin
      res_q   <= '0;
    end else if (in_sar && cmp_i) begin
      res_q   <= res_q | mask;
    end
  end

  assign trial_o = in_sar ? (res_q | mask) : '0;
  assign code_o  = res_q;
  assign ready_o = armed_q && (step == phase_t'(STEP_XFER));
endmodule

// File: rtl/tis_out_stage.sv
module tis_out_stage
  import tis_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  phase_t                       phase_i,
  input  logic [SLICES-1:0][SAR_W-1:0] codes_i,
  input  logic [SLICES-1:0]            ready_i,
  output logic [DATA_W-1:0]            data_o,
  output logic                         ovr_o,
  output logic                         dav_o
);
  phase_t sel;
  code_t  pick;

  // slice in transfer step: phase - IDX == SLICES-1
  assign sel  = phase_i + phase_t'(1);
  assign pick = codes_i[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      ovr_o  <= 1'b0;
      dav_o  <= 1'b0;
    end else if (ready_i[sel]) begin
      dav_o <= 1'b1;
      if (pick[SAR_W-1]) begin
        data_o <= '1;
        ovr_o  <= 1'b1;
      end else begin
        data_o <= pick[DATA_W-1:0];
        ovr_o  <= 1'b0;
      end
    end else begin
      dav_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tis_channel.sv
module tis_channel
  import tis_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SLICES-1:0]       cmp_i,
  output logic [SLICES*SAR_W-1:0] trial_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    ovr_o,
  output logic                    dav_o
);
  phase_t                       phase;
  logic [SLICES-1:0][SAR_W-1:0] codes;
  logic [SLICES-1:0]            ready;

  tis_phase_gen u_phase (.clk_i(clk_i), .rst_ni(rst_ni), .phase_o(phase));

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    tis_sar_slice #(.IDX(k)) u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .phase_i (phase),
      .cmp_i   (cmp_i[k]),
      .trial_o (trial_o[k*SAR_W +: SAR_W]),
      .code_o  (codes[k]),
      .ready_o (ready[k])
    );
  end

  tis_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .codes_i (codes),
    .ready_i (ready),
    .data_o  (data_o),
    .ovr_o   (ovr_o),
    .dav_o   (dav_o)
  );
endmodule

// File: rtl/tis_dual_top.sv
module tis_dual_top
  import tis_pkg::*;
(
  input  logic                    clk_a_i,
  input  logic                    rst_a_ni,
  input  logic [SLICES-1:0]       cmp_a_i,
  output logic [SLICES*SAR_W-1:0] trial_a_o,
  input  logic                    clk_b_i,
  input  logic                    rst_b_ni,
  input  logic [SLICES-1:0]       cmp_b_i,
  output logic [SLICES*SAR_W-1:0] trial_b_o,
  input  logic                    oe_ni,
  output logic [DATA_W-1:0]       data_a_o,
  output logic                    ovr_a_o,
  output logic                    dav_a_o,
  output logic [DATA_W-1:0]       data_b_o,
  output logic                    ovr_b_o,
  output logic                    dav_b_o
);
  logic [DATA_W-1:0] data_a, data_b;
  logic              ovr_a, ovr_b;

  tis_channel u_ch_a (
    .clk_i(clk_a_i), .rst_ni(rst_a_ni), .cmp_i(cmp_a_i), .trial_o(trial_a_o),
    .data_o(data_a), .ovr_o(ovr_a), .dav_o(dav_a_o)
  );

  tis_channel u_ch_b (
    .clk_i(clk_b_i), .rst_ni(rst_b_ni), .cmp_i(cmp_b_i), .trial_o(trial_b_o),
    .data_o(data_b), .ovr_o(ovr_b), .dav_o(dav_b_o)
  );

  assign data_a_o = oe_ni ? 'z   : data_a;
  assign ovr_a_o  = oe_ni ? 1'bz : ovr_a;
  assign data_b_o = oe_ni ? 'z   : data_b;
  assign ovr_b_o  = oe_ni ? 1'bz : ovr_b;
endmodule

// File: rtl/tis_dual_chk.sv
module tis_dual_chk
  import tis_pkg::*;
(
  input logic                    clk_a_i,
  input logic                    rst_a_ni,
  input logic [SLICES*SAR_W-1:0] trial_a_o,
  input logic                    clk_b_i,
  input logic                    rst_b_ni,
  input logic [SLICES*SAR_W-1:0] trial_b_o,
  input logic                    oe_ni,
  input logic [DATA_W-1:0]       data_a_o,
  input logic                    ovr_a_o,
  input logic                    dav_a_o,
  input logic [DATA_W-1:0]       data_b_o,
  input logic                    ovr_b_o,
  input logic                    dav_b_o
);
  localparam code_t FIRST = code_t'(1) << (SAR_W - 1);

  logic [PH_W:0]     cnt_a, cnt_b;
  logic [SLICES-1:0] act_a, act_b, first_a, first_b;

  always_ff @(posedge clk_a_i or negedge rst_a_ni) begin
    if (!rst_a_ni) cnt_a <= '0;
    else if (cnt_a < (PH_W+1)'(SLICES)) cnt_a <= cnt_a + 1'b1;
  end
  always_ff @(posedge clk_b_i or negedge rst_b_ni) begin
    if (!rst_b_ni) cnt_b <= '0;
    else if (cnt_b < (PH_W+1)'(SLICES)) cnt_b <= cnt_b + 1'b1;
  end

  always_comb begin
    for (int k = 0; k < SLICES; k++) begin
      act_a[k]   = trial_a_o[k*SAR_W +: SAR_W] != '0;
      act_b[k]   = trial_b_o[k*SAR_W +: SAR_W] != '0;
      first_a[k] = trial_a_o[k*SAR_W +: SAR_W] == FIRST;
      first_b[k] = trial_b_o[k*SAR_W +: SAR_W] == FIRST;
    end
  end

  p_search_count_a_r2: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    $countones(act_a) == SAR_W);
  p_search_count_b_r2: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    $countones(act_b) == SAR_W);
  p_one_sampler_a_r2: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    $countones(first_a) == 1);
  p_one_sampler_b_r2: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    $countones(first_b) == 1);
  p_saturate_a_r6: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    (!oe_ni && ovr_a_o === 1'b1) |-> (data_a_o == '1));
  p_saturate_b_r6: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    (!oe_ni && ovr_b_o === 1'b1) |-> (data_b_o == '1));
  p_dav_quiet_a_r7: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    (cnt_a < (PH_W+1)'(SLICES)) |-> !dav_a_o);
  p_dav_on_a_r7: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    (cnt_a == (PH_W+1)'(SLICES)) |-> dav_a_o);
  p_dav_quiet_b_r7: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    (cnt_b < (PH_W+1)'(SLICES)) |-> !dav_b_o);
  p_dav_on_b_r7: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    (cnt_b == (PH_W+1)'(SLICES)) |-> dav_b_o);
endmodule

bind tis_dual_top tis_dual_chk u_chk (.*);

// File: tb/tis_dual_top_tb_top.sv
module tis_dual_top_tb_top;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int NS   = 16;
  localparam int SW   = 11;
  localparam int NCYC = 2200;

  logic             clk_a = 1'b0, clk_b = 1'b0;
  logic             rst_a_n = 1'b0, rst_b_n = 1'b0, oe_n = 1'b0;
  logic [NS-1:0]    cmp_a, cmp_b;
  logic [NS*SW-1:0] trial_a, trial_b;
  logic [9:0]       data_a, data_b;
  logic             ovr_a, ovr_b, dav_a, dav_b;
  logic [SW-1:0]    held_a [NS];
  logic [SW-1:0]    held_b [NS];
  logic             noise_a = 1'b0, noise_b = 1'b0;
  bit               done_a = 1'b0, done_b = 1'b0;
  int               n_chk = 0, n_fail = 0;

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  tis_dual_top dut_i (
    .clk_a_i(clk_a), .rst_a_ni(rst_a_n), .cmp_a_i(cmp_a), .trial_a_o(trial_a),
    .clk_b_i(clk_b), .rst_b_ni(rst_b_n), .cmp_b_i(cmp_b), .trial_b_o(trial_b),
    .oe_ni(oe_n),
    .data_a_o(data_a), .ovr_a_o(ovr_a), .dav_a_o(dav_a),
    .data_b_o(data_b), .ovr_b_o(ovr_b), .dav_b_o(dav_b)
  );

  // behavioural comparator: answers only while searching, noise otherwise (R4)
  always_comb begin
    for (int k = 0; k < NS; k++) begin
      cmp_a[k] = (trial_a[k*SW +: SW] != '0) ? (held_a[k] >= trial_a[k*SW +: SW]) : noise_a;
      cmp_b[k] = (trial_b[k*SW +: SW] != '0) ? (held_b[k] >= trial_b[k*SW +: SW]) : noise_b;
    end
  end

  function automatic int ana_a(int c); return c % 2048; endfunction
  function automatic int ana_b(int c); return (c * 37 + 5) % 2048; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit search_ok(input logic [NS*SW-1:0] tr, input int n);
    for (int k = 0; k < NS; k++) begin
      int  st = (n - k) & 15;
      bit  on = (st >= 4) && (st <= 14);
      if ((tr[k*SW +: SW] != '0) != on) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic out_chk(input int n, input int code, input logic [9:0] d, input logic o,
                         input logic v, input string tag);
    int exp_d;
    bit exp_o;
    chk(v == (n >= 16), {tag, " R7 dav"}, int'(v), int'(n >= 16));
    if (oe_n) begin
      chk((d === 10'bz || d === 10'd0) && (o === 1'bz || o === 1'b0),
          {tag, " R8 hi-z"}, int'(d), 0);
    end else if (n < 16) begin
      chk(d == 10'd0 && o == 1'b0, {tag, " R1 idle word"}, int'(d), 0);
    end else begin
      exp_o = code >= 1024;
      exp_d = exp_o ? 1023 : code;
      chk(d == 10'(exp_d), {tag, " R3 R5 R6 data"}, int'(d), exp_d);
      chk(o == exp_o, {tag, " R6 ovr"}, int'(o), int'(exp_o));
    end
  endtask

  initial begin : chan_a
    for (int k = 0; k < NS; k++) held_a[k] = '0;
    repeat (3) @(negedge clk_a);
    chk(dav_a == 1'b0 && data_a == 10'd0, "A R1 reset", int'(dav_a), 0);
    rst_a_n = 1'b1;
    for (int n = 0; n < NCYC; n++) begin
      held_a[(n + 13) % 16] = SW'(ana_a(n));
      noise_a = ~noise_a;
      if (n == 1000) oe_n = 1'b1;
      if (n == 1020) oe_n = 1'b0;
      #1;
      chk(search_ok(trial_a, n), "A R2 schedule", n, n);
      out_chk(n, ana_a(n - 13), data_a, ovr_a, dav_a, "A");
      @(negedge clk_a);
    end
    done_a = 1'b1;
  end

  initial begin : chan_b
    for (int k = 0; k < NS; k++) held_b[k] = '0;
    repeat (40) @(negedge clk_b);
    chk(dav_b == 1'b0 && data_b == 10'd0, "B R9 R1 held in reset", int'(dav_b), 0);
    rst_b_n = 1'b1;
    for (int n = 0; n < NCYC; n++) begin
      held_b[(n + 13) % 16] = SW'(ana_b(n));
      noise_b = ~noise_b;
      #1;
      chk(search_ok(trial_b, n), "B R9 R2 schedule", n, n);
      out_chk(n, ana_b(n - 13), data_b, ovr_b, dav_b, "B R9");
      @(negedge clk_b);
    end
    done_b = 1'b1;
  end

  initial begin : finish_ctl
    fork
      wait (done_a && done_b);
      begin
        #(CLK_B_PERIOD * 20000);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule